// File: doc/BRIEF.md
# Processor Status Trace Encoder

This block converts execution events from a simple in-order core into a real-time debug trace. On every clock it drives a 4-bit status code on `pst_o` and a 4-bit data nibble on `ddata_o`. The core hands over one event per transfer on a valid/ready stream: an instruction start (ordinary or data-write), an operand capture with one or two values, a read-modify-write operand pair, a taken branch with its target and addressing mode, a normal exception entry carrying its stack-frame value, vector value and handler address, or a reset exception.

Each event becomes a fixed sequence of trace cycles: a head code, optional marker cycles, and the captured value sent out one nibble per clock, least-significant nibble first. Events wait in a small FIFO so that long expansions never lose what follows them. When the FIFO is full, `ev_ready` is low, and this low ready is the stall request to the core: the core must hold `ev_valid` and its event fields until ready returns. An event transfers on a clock edge where both `ev_valid` and `ev_ready` are high. `ev_ready` depends only on FIFO occupancy and never on `ev_valid`. Two configuration pins separately enable the display of operand data and of target addresses. They are read when an event leaves the FIFO, so they should only change while the block is idle.

Top module: `pst_trace_enc`

## Requirements
- R1: While reset is asserted and on the first cycle after it, `pst_o` and `ddata_o` are 0x0 and `ev_ready` is 1.
- R2: An ordinary instruction start (kind 0) emits `pst_o`=0x1 for one cycle, and a data-write instruction start (kind 1) emits 0x4. A cycle with no trace activity shows `pst_o`=0x0 and `ddata_o`=0x0.
- R3: An operand capture (kind 2) with data display enabled emits a marker cycle, then the value on `ddata_o` one nibble per cycle, least-significant nibble first, with `pst_o`=0x0 during the data. The size field is 0 for a byte (marker 0x8, 2 nibbles), 1 for a word (marker 0x9, 4 nibbles), and 2 or 3 for a longword (marker 0xB, 8 nibbles). Marker cycles drive `ddata_o`=0x0.
- R4: A read-modify-write capture (kind 3) emits the source value (`ev_opa`) as a full marker-plus-data capture first, then the destination value (`ev_opb`) as a second capture, both sized as in R3.
- R5: An operand or read-modify-write capture flagged as a line-sized burst (`ev_burst`=1) never emits a marker or data, whatever the configuration.
- R6: With `cfg_show_data`=0, no operand, read-modify-write, stack-frame or vector capture is emitted. With `cfg_show_addr`=0, no branch-target or handler-address capture is emitted. Head codes, 0x5 and 0xC are still emitted in both cases.
- R7: A taken branch (kind 4) emits 0x5. The target address follows it only when `cfg_show_addr`=1 and the addressing-mode code is 0 (register indirect), 1 (indirect with 16-bit displacement), 2 (indexed from a register) or 3 (indexed from the program counter). Codes 4 to 7 never show the target.
- R8: A shown address uses marker 0x9 with 4 nibbles when its upper 16 bits are zero, otherwise marker 0xA with 6 nibbles when its upper 8 bits are zero, otherwise marker 0xB with 8 nibbles.
- R9: A normal exception (kind 5) emits the following in order: 0xC; the stack-frame value (`ev_opa`) as marker 0xB plus 8 nibbles; the vector value (`ev_opb`) as marker 0xB plus 8 nibbles; 0x5; and the handler address sized as in R8. `pst_o` is 0xC on every data cycle of the exception.
- R10: A reset exception (kind 6) emits only a single 0xC cycle and never captures any operand or address, whatever the configuration.
- R11: Events leave in their arrival order, and none is dropped. `ev_ready` is low exactly while the FIFO holds its full depth. Expansions of queued events follow one another with no idle cycle. An event that produces no output at all (suppressed or kind 7) occupies one idle cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ev_valid | input | 1 | Event offered by the core |
| ev_ready | output | 1 | Event accepted. Low means stall the core |
| ev_kind | input | 3 | 0 insn, 1 write insn, 2 operand, 3 read-modify-write, 4 branch, 5 exception, 6 reset, 7 none |
| ev_size | input | 2 | Operand size: 0 byte, 1 word, 2 or 3 longword |
| ev_burst | input | 1 | Operand belongs to a line-sized burst move |
| ev_amode | input | 3 | Branch addressing-mode code (0 to 3 are variant modes) |
| ev_opa | input | 32 | Source operand, or exception stack-frame value |
| ev_opb | input | 32 | Destination operand, or exception vector value |
| ev_addr | input | 32 | Branch target or exception handler address |
| cfg_show_data | input | 1 | Enable operand, frame and vector captures |
| cfg_show_addr | input | 1 | Enable target and handler address captures |
| pst_o | output | 4 | Processor status code |
| ddata_o | output | 4 | Debug data nibble |

## Verification
The hardest state to reach from the ports is a full event FIFO while a long exception expansion is still running and further events are waiting behind it. This state exercises the stall, the handoff from one expansion to the next, and the one-cycle slot left by a fully suppressed event. The stimulus reaches it by streaming a complete list of event kinds, sizes, burst flags, addressing modes and address widths back to back under each of the four configuration settings. With data display on, three consecutive exceptions fill the FIFO and drop `ev_ready`. The bench then predicts the whole concatenated trace cycle by cycle from the requirements and compares every sample.

// File: rtl/pst_trace_pkg.sv
package pst_trace_pkg;

  localparam int TR_DW    = 32;
  localparam int TR_NIBS  = TR_DW / 4;
  localparam int TR_NIB_W = $clog2(TR_NIBS + 1);
  localparam int NSEG     = 3;
  localparam int SEG_W    = $clog2(NSEG);

  typedef enum logic [2:0] {
    EV_INSN    = 3'd0,
    EV_INSN_WR = 3'd1,
    EV_OPND    = 3'd2,
    EV_RMW     = 3'd3,
    EV_BRANCH  = 3'd4,
    EV_EXC     = 3'd5,
    EV_RESET   = 3'd6,
    EV_NONE    = 3'd7
  } ev_kind_e;

  typedef enum logic [3:0] {
    PST_IDLE    = 4'h0,
    PST_INSN    = 4'h1,
    PST_INSN_WR = 4'h4,
    PST_TAKEN   = 4'h5,
    PST_MK_B    = 4'h8,
    PST_MK_W    = 4'h9,
    PST_MK_3    = 4'hA,
    PST_MK_L    = 4'hB,
    PST_EXC     = 4'hC
  } pst_code_e;

  typedef struct packed {
    ev_kind_e           kind;
    logic [1:0]         size;
    logic               burst;
    logic [2:0]         amode;
    logic [TR_DW-1:0]   opa;
    logic [TR_DW-1:0]   opb;
    logic [TR_DW-1:0]   addr;
  } trace_ev_t;

  // One capture slot: optional 0x5 prefix, then marker and nibbles.
  typedef struct packed {
    logic                pre_en;
    logic                cap_en;
    logic [3:0]          marker;
    logic [TR_NIB_W-1:0] nnib;
    logic [TR_DW-1:0]    val;
  } seg_t;

  typedef struct packed {
    logic                  head_en;
    logic [3:0]            head;
    logic                  exc;
    seg_t [NSEG-1:0]       seg;
  } plan_t;

endpackage

// File: rtl/pst_ev_fifo.sv
module pst_ev_fifo
  import pst_trace_pkg::*;
#(
  parameter int DEPTH = 4,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       push,
  input  trace_ev_t  din,
  input  logic       pop,
  output trace_ev_t  dout,
  output logic       full,
  output logic       empty,
  output logic [CW-1:0] count
);

  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  trace_ev_t         mem [DEPTH];
  logic [AW-1:0]     wptr, rptr;
  logic              do_push, do_pop;

  assign full    = (count == CW'(DEPTH));
  assign empty   = (count == '0);
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign dout    = mem[rptr];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr  <= '0;
      rptr  <= '0;
      count <= '0;
    end else begin
      if (do_push) wptr <= (wptr == LAST) ? '0 : wptr + 1'b1;
      if (do_pop)  rptr <= (rptr == LAST) ? '0 : rptr + 1'b1;
      case ({do_push, do_pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem[wptr] <= din;
  end

  AST_FIFO_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(DEPTH)); // R11

  AST_FULL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (full && !pop) |=> full); // R11

endmodule

// File: rtl/pst_ev_plan.sv
module pst_ev_plan
  import pst_trace_pkg::*;
(
  input  trace_ev_t ev,
  input  logic      show_data,
  input  logic      show_addr,
  output plan_t     plan
);

  function automatic logic [3:0] size_marker(logic [1:0] sz);
    case (sz)
      2'd0:    return PST_MK_B;
      2'd1:    return PST_MK_W;
      default: return PST_MK_L;
    endcase
  endfunction

  function automatic logic [TR_NIB_W-1:0] size_nibs(logic [1:0] sz);
    case (sz)
      2'd0:    return TR_NIB_W'(2);
      2'd1:    return TR_NIB_W'(4);
      default: return TR_NIB_W'(TR_NIBS);
    endcase
  endfunction

  // Address width chosen from the leading zero bytes of the address.
  function automatic logic [3:0] addr_marker(logic [TR_DW-1:0] a);
    if (a[TR_DW-1:16] == '0)      return PST_MK_W;
    else if (a[TR_DW-1:24] == '0) return PST_MK_3;
    else                          return PST_MK_L;
  endfunction

  function automatic logic [TR_NIB_W-1:0] addr_nibs(logic [TR_DW-1:0] a);
    if (a[TR_DW-1:16] == '0)      return TR_NIB_W'(4);
    else if (a[TR_DW-1:24] == '0) return TR_NIB_W'(6);
    else                          return TR_NIB_W'(TR_NIBS);
  endfunction

  logic opnd_on;
  logic variant;

  assign opnd_on = show_data && !ev.burst;
  assign variant = (ev.amode <= 3'd3);

  always_comb begin
    plan = '0;
    unique case (ev.kind)
      EV_INSN: begin
        plan.head_en = 1'b1;
        plan.head    = PST_INSN;
      end
      EV_INSN_WR: begin
        plan.head_en = 1'b1;
        plan.head    = PST_INSN_WR;
      end
      EV_OPND: begin
        plan.seg[0].cap_en = opnd_on;
        plan.seg[0].marker = size_marker(ev.size);
        plan.seg[0].nnib   = size_nibs(ev.size);
        plan.seg[0].val    = ev.opa;
      end
      EV_RMW: begin
        plan.seg[0].cap_en = opnd_on;
        plan.seg[0].marker = size_marker(ev.size);
        plan.seg[0].nnib   = size_nibs(ev.size);
        plan.seg[0].val    = ev.opa;
        plan.seg[1].cap_en = opnd_on;
        plan.seg[1].marker = size_marker(ev.size);
        plan.seg[1].nnib   = size_nibs(ev.size);
        plan.seg[1].val    = ev.opb;
      end
      EV_BRANCH: begin
        plan.head_en       = 1'b1;
        plan.head          = PST_TAKEN;
        plan.seg[0].cap_en = show_addr && variant;
        plan.seg[0].marker = addr_marker(ev.addr);
        plan.seg[0].nnib   = addr_nibs(ev.addr);
        plan.seg[0].val    = ev.addr;
      end
      EV_EXC: begin
        plan.exc           = 1'b1;
        plan.head_en       = 1'b1;
        plan.head          = PST_EXC;
        plan.seg[0].cap_en = show_data;
        plan.seg[0].marker = PST_MK_L;
        plan.seg[0].nnib   = TR_NIB_W'(TR_NIBS);
        plan.seg[0].val    = ev.opa;
        plan.seg[1].cap_en = show_data;
        plan.seg[1].marker = PST_MK_L;
        plan.seg[1].nnib   = TR_NIB_W'(TR_NIBS);
        plan.seg[1].val    = ev.opb;
        plan.seg[2].pre_en = 1'b1;
        plan.seg[2].cap_en = show_addr;
        plan.seg[2].marker = addr_marker(ev.addr);
        plan.seg[2].nnib   = addr_nibs(ev.addr);
        plan.seg[2].val    = ev.addr;
      end
      EV_RESET: begin
        plan.exc     = 1'b1;
        plan.head_en = 1'b1;
        plan.head    = PST_EXC;
      end
      default: plan = '0;
    endcase
  end

endmodule

// File: rtl/pst_serializer.sv
module pst_serializer
  import pst_trace_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       head_valid,
  input  plan_t      head_plan,
  output logic       pop,
  output logic [3:0] pst_o,
  output logic [3:0] ddata_o
);

  // Phase 0 is the head; each slot k owns phases 1+3k (prefix),
  // 2+3k (marker) and 3+3k (data); PH_DONE means nothing left.
  localparam int NPH  = 1 + 3 * NSEG;
  localparam int PH_W = $clog2(NPH + 1);
  localparam logic [PH_W-1:0] PH_DONE = PH_W'(NPH);

  typedef enum logic [2:0] {K_NONE, K_HEAD, K_PRE, K_MARK, K_DATA} pkind_e;

  function automatic logic ph_en(plan_t p, logic [PH_W-1:0] q);
    logic [PH_W-1:0] ix;
    logic [SEG_W-1:0] s;
    if (q == '0) return p.head_en;
    if (q >= PH_DONE) return 1'b0;
    ix = q - 1'b1;
    s  = SEG_W'(ix / PH_W'(3));
    if ((ix % PH_W'(3)) == '0) return p.seg[s].pre_en;
    return p.seg[s].cap_en;
  endfunction

  function automatic logic [PH_W-1:0] first_from(plan_t p, logic [PH_W-1:0] start);
    logic [PH_W-1:0] r;
    logic hit;
    r   = PH_DONE;
    hit = 1'b0;
    for (int q = 0; q < NPH; q++) begin
      if (!hit && (PH_W'(q) >= start) && ph_en(p, PH_W'(q))) begin
        r   = PH_W'(q);
        hit = 1'b1;
      end
    end
    return r;
  endfunction

  logic                 busy, busy_n;
  plan_t                pl, pl_n, eplan;
  logic [PH_W-1:0]      ph, ph_n, eph, nxt, rel;
  logic [TR_NIB_W-1:0]  left, left_n;
  logic [TR_DW-1:0]     shreg, sh_n;
  logic [SEG_W-1:0]     sidx;
  pkind_e               ekind;
  seg_t                 cseg;
  logic [3:0]           emit_pst, emit_dd;

  always_comb begin
    pop   = !busy && head_valid;
    eplan = busy ? pl : head_plan;
    if (busy)            eph = ph;
    else if (head_valid) eph = first_from(head_plan, '0);
    else                 eph = PH_DONE;

    rel   = (eph == '0) ? '0 : eph - 1'b1;
    sidx  = SEG_W'(rel / PH_W'(3));
    cseg  = eplan.seg[sidx];
    ekind = K_NONE;
    if (eph == '0) ekind = K_HEAD;
    else if (eph < PH_DONE) begin
      case (rel % PH_W'(3))
        PH_W'(0): ekind = K_PRE;
        PH_W'(1): ekind = K_MARK;
        default:  ekind = K_DATA;
      endcase
    end

    emit_pst = PST_IDLE;
    emit_dd  = 4'h0;
    case (ekind)
      K_HEAD: emit_pst = eplan.head;
      K_PRE:  emit_pst = PST_TAKEN;
      K_MARK: emit_pst = cseg.marker;
      K_DATA: begin
        emit_pst = eplan.exc ? PST_EXC : PST_IDLE;
        emit_dd  = shreg[3:0];
      end
      default: ;
    endcase

    busy_n = busy;
    pl_n   = pl;
    ph_n   = ph;
    left_n = left;
    sh_n   = shreg;
    nxt    = first_from(eplan, eph + 1'b1);
    if (ekind != K_NONE) begin
      pl_n = eplan;
      if (ekind == K_DATA && left > TR_NIB_W'(1)) begin
        busy_n = 1'b1;
        ph_n   = eph;
        left_n = left - 1'b1;
        sh_n   = shreg >> 4;
      end else begin
        ph_n   = nxt;
        busy_n = (nxt != PH_DONE);
        if (ekind == K_MARK) begin
          sh_n   = cseg.val;
          left_n = cseg.nnib;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      pl      <= '0;
      ph      <= PH_DONE;
      left    <= '0;
      shreg   <= '0;
      pst_o   <= PST_IDLE;
      ddata_o <= 4'h0;
    end else begin
      busy    <= busy_n;
      pl      <= pl_n;
      ph      <= ph_n;
      left    <= left_n;
      shreg   <= sh_n;
      pst_o   <= emit_pst;
      ddata_o <= emit_dd;
    end
  end

  AST_PST_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    pst_o inside {4'h0, 4'h1, 4'h4, 4'h5, 4'h8, 4'h9, 4'hA, 4'hB, 4'hC}); // R2

  AST_MARK_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (pst_o inside {4'h1, 4'h4, 4'h5, 4'h8, 4'h9, 4'hA, 4'hB}) |-> ddata_o == 4'h0); // R3

  AST_MARK_THEN_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    (pst_o inside {4'h8, 4'h9, 4'hA, 4'hB}) |=> (pst_o == 4'h0 || pst_o == 4'hC)); // R3

endmodule

// File: rtl/pst_trace_enc.sv
module pst_trace_enc
  import pst_trace_pkg::*;
#(
  parameter int EV_DEPTH = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ev_valid,
  output logic             ev_ready,
  input  logic [2:0]       ev_kind,
  input  logic [1:0]       ev_size,
  input  logic             ev_burst,
  input  logic [2:0]       ev_amode,
  input  logic [TR_DW-1:0] ev_opa,
  input  logic [TR_DW-1:0] ev_opb,
  input  logic [TR_DW-1:0] ev_addr,
  input  logic             cfg_show_data,
  input  logic             cfg_show_addr,
  output logic [3:0]       pst_o,
  output logic [3:0]       ddata_o
);

  localparam int CW = $clog2(EV_DEPTH + 1);

  trace_ev_t     in_ev, head_ev;
  plan_t         head_plan;
  logic          q_full, q_empty, q_pop;
  logic [CW-1:0] q_count;

  always_comb begin
    in_ev.kind  = ev_kind_e'(ev_kind);
    in_ev.size  = ev_size;
    in_ev.burst = ev_burst;
    in_ev.amode = ev_amode;
    in_ev.opa   = ev_opa;
    in_ev.opb   = ev_opb;
    in_ev.addr  = ev_addr;
  end

  assign ev_ready = !q_full;

  pst_ev_fifo #(.DEPTH(EV_DEPTH)) u_fifo (
    .clk   (clk),
    .rst_n (rst_n),
    .push  (ev_valid && ev_ready),
    .din   (in_ev),
    .pop   (q_pop),
    .dout  (head_ev),
    .full  (q_full),
    .empty (q_empty),
    .count (q_count)
  );

  pst_ev_plan u_plan (
    .ev        (head_ev),
    .show_data (cfg_show_data),
    .show_addr (cfg_show_addr),
    .plan      (head_plan)
  );

  pst_serializer u_ser (
    .clk        (clk),
    .rst_n      (rst_n),
    .head_valid (!q_empty),
    .head_plan  (head_plan),
    .pop        (q_pop),
    .pst_o      (pst_o),
    .ddata_o    (ddata_o)
  );

  AST_NO_POP_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    q_pop |-> !q_empty); // R11

  AST_READY_ROOM: assert property (@(posedge clk) disable iff (!rst_n)
    (q_count < CW'(EV_DEPTH)) |-> ev_ready); // R11

endmodule

// File: tb/tb_pst_trace_enc.sv
module tb_pst_trace_enc;

  localparam int CLK_PERIOD = 10;
  localparam int MAXE = 2048;
  localparam int MAXV = 64;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ev_valid = 1'b0;
  logic        ev_ready;
  logic [2:0]  ev_kind = '0;
  logic [1:0]  ev_size = '0;
  logic        ev_burst = 1'b0;
  logic [2:0]  ev_amode = '0;
  logic [31:0] ev_opa = '0, ev_opb = '0, ev_addr = '0;
  logic        cfg_show_data = 1'b0, cfg_show_addr = 1'b0;
  logic [3:0]  pst_o, ddata_o;

  int errors = 0;
  int checks = 0;

  // event list
  logic [2:0]  vk [MAXV];
  logic [1:0]  vs [MAXV];
  logic        vb [MAXV];
  logic [2:0]  vm [MAXV];
  logic [31:0] va [MAXV], vo [MAXV], vd [MAXV];
  int nev;

  // expected trace
  logic [3:0] xp [MAXE];
  logic [3:0] xd [MAXE];
  string      xt [MAXE];
  int nexp;

  always #(CLK_PERIOD/2) clk = ~clk;

  pst_trace_enc dut (
    .clk(clk), .rst_n(rst_n), .ev_valid(ev_valid), .ev_ready(ev_ready),
    .ev_kind(ev_kind), .ev_size(ev_size), .ev_burst(ev_burst), .ev_amode(ev_amode),
    .ev_opa(ev_opa), .ev_opb(ev_opb), .ev_addr(ev_addr),
    .cfg_show_data(cfg_show_data), .cfg_show_addr(cfg_show_addr),
    .pst_o(pst_o), .ddata_o(ddata_o)
  );

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic put(input logic [3:0] p, input logic [3:0] d, input string t);
    xp[nexp] = p; xd[nexp] = d; xt[nexp] = t; nexp++;
  endtask

  task automatic put_cap(input logic [3:0] mk, input logic [31:0] v, input int n,
                         input logic [3:0] bg, input string t);
    put(mk, 4'h0, t);
    for (int j = 0; j < n; j++) put(bg, 4'((v >> (4 * j)) & 32'hF), t);
  endtask

  function automatic logic [3:0] amk(input logic [31:0] a);
    if (a[31:16] == 0) return 4'h9;
    if (a[31:24] == 0) return 4'hA;
    return 4'hB;
  endfunction

  function automatic int anib(input logic [31:0] a);
    if (a[31:16] == 0) return 4;
    if (a[31:24] == 0) return 6;
    return 8;
  endfunction

  function automatic logic [31:0] pick_addr(input int i, input int salt);
    case (i % 3)
      0:       return 32'h0000_3A5C + 32'(salt);
      1:       return 32'h00C1_2F0E + 32'(salt * 16);
      default: return 32'h8A40_0F12 + 32'(salt * 256);
    endcase
  endfunction

  task automatic add_ev(input logic [2:0] k, input logic [1:0] s, input logic b,
                        input logic [2:0] m, input logic [31:0] a, input logic [31:0] o,
                        input logic [31:0] d);
    vk[nev] = k; vs[nev] = s; vb[nev] = b; vm[nev] = m;
    va[nev] = a; vo[nev] = o; vd[nev] = d; nev++;
  endtask

  task automatic build_list();
    nev = 0;
    add_ev(3'd0, 2'd0, 1'b0, 3'd0, 32'hFFFF_FFFF, 32'h1, 32'h2);
    add_ev(3'd1, 2'd0, 1'b0, 3'd0, 32'h0, 32'h0, 32'h0);
    for (int s = 0; s < 4; s++)
      for (int b = 0; b < 2; b++)
        add_ev(3'd2, 2'(s), 1'(b), 3'd0, 32'hA1B2_C3D4 + 32'(s * 32'h0101_0101 + b * 7),
               32'h0, 32'h0);
    for (int s = 0; s < 3; s++)
      for (int b = 0; b < 2; b++)
        add_ev(3'd3, 2'(s), 1'(b), 3'd0, 32'h1357_9BDF ^ 32'(s * 32'h1111_0000 + b),
               32'hFEDC_BA98 - 32'(s * 32'h0022_0033), 32'h0);
    for (int m = 0; m < 8; m++)
      add_ev(3'd4, 2'd0, 1'b0, 3'(m), 32'h0, 32'h0, pick_addr(m, m));
    for (int h = 0; h < 3; h++)
      add_ev(3'd5, 2'd0, 1'b0, 3'd0, 32'h4E71_0000 + 32'(h * 32'h0301),
             32'h0000_0100 + 32'(h * 4), pick_addr(h, 5 + h));
    add_ev(3'd6, 2'd2, 1'b0, 3'd0, 32'h0000_0000, 32'h0000_0004, 32'h8000_0000);
    add_ev(3'd0, 2'd0, 1'b0, 3'd0, 32'h0, 32'h0, 32'h0);
    add_ev(3'd7, 2'd2, 1'b0, 3'd0, 32'hDEAD_BEEF, 32'h0, 32'h0);
    add_ev(3'd1, 2'd0, 1'b0, 3'd0, 32'h0, 32'h0, 32'h0);
  endtask

  task automatic expand(input int i, input bit de, input bit ae);
    logic [3:0] mk;
    int n;
    case (vs[i])
      2'd0:    begin mk = 4'h8; n = 2; end
      2'd1:    begin mk = 4'h9; n = 4; end
      default: begin mk = 4'hB; n = 8; end
    endcase
    case (vk[i])
      3'd0: put(4'h1, 4'h0, "R2");
      3'd1: put(4'h4, 4'h0, "R2");
      3'd2: begin
        if (de && !vb[i]) put_cap(mk, va[i], n, 4'h0, "R3");
        else put(4'h0, 4'h0, vb[i] ? "R5" : "R6");
      end
      3'd3: begin
        if (de && !vb[i]) begin
          put_cap(mk, va[i], n, 4'h0, "R4");
          put_cap(mk, vo[i], n, 4'h0, "R4");
        end else put(4'h0, 4'h0, vb[i] ? "R5" : "R6");
      end
      3'd4: begin
        put(4'h5, 4'h0, "R7");
        if (ae && vm[i] <= 3'd3) put_cap(amk(vd[i]), vd[i], anib(vd[i]), 4'h0, "R8");
      end
      3'd5: begin
        put(4'hC, 4'h0, "R9");
        if (de) begin
          put_cap(4'hB, va[i], 8, 4'hC, "R9");
          put_cap(4'hB, vo[i], 8, 4'hC, "R9");
        end
        put(4'h5, 4'h0, "R9");
        if (ae) put_cap(amk(vd[i]), vd[i], anib(vd[i]), 4'hC, "R8");
      end
      3'd6: put(4'hC, 4'h0, "R10");
      default: put(4'h0, 4'h0, "R11");
    endcase
  endtask

  task automatic run_cfg(input bit de, input bit ae);
    bit saw_low;
    build_list();
    nexp = 0;
    for (int i = 0; i < nev; i++) expand(i, de, ae);
    cfg_show_data = de;
    cfg_show_addr = ae;
    saw_low = 1'b0;
    @(negedge clk);
    fork
      begin
        for (int i = 0; i < nev; i++) begin
          ev_kind = vk[i]; ev_size = vs[i]; ev_burst = vb[i]; ev_amode = vm[i];
          ev_opa = va[i]; ev_opb = vo[i]; ev_addr = vd[i];
          ev_valid = 1'b1;
          while (!ev_ready) begin saw_low = 1'b1; @(negedge clk); end
          @(negedge clk);
        end
        ev_valid = 1'b0;
      end
      begin
        for (int s = 0; s < nexp + 6; s++) begin
          if (s >= 2 && s < nexp + 2) begin
            check(pst_o == xp[s-2] && ddata_o == xd[s-2], xt[s-2],
                  $sformatf("cfg %0d%0d cycle %0d pst/ddata", de, ae, s - 2),
                  {24'h0, pst_o, ddata_o}, {24'h0, xp[s-2], xd[s-2]});
          end else if (s >= nexp + 2) begin
            check(pst_o == 4'h0 && ddata_o == 4'h0, "R2", "idle after drain",
                  {24'h0, pst_o, ddata_o}, 32'h0);
          end
          @(negedge clk);
        end
      end
    join
    // R11: long exception expansions must fill the queue and stall the core
    if (de) check(saw_low, "R11", "back-pressure observed", 32'(saw_low), 32'h1);
    check(ev_ready == 1'b1, "R11", "ready after drain", 32'(ev_ready), 32'h1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(pst_o == 4'h0 && ddata_o == 4'h0, "R1", "outputs in reset",
          {24'h0, pst_o, ddata_o}, 32'h0);
    check(ev_ready == 1'b1, "R1", "ready in reset", 32'(ev_ready), 32'h1);
    rst_n = 1'b1;
    @(negedge clk);
    check(pst_o == 4'h0 && ddata_o == 4'h0, "R1", "outputs after reset",
          {24'h0, pst_o, ddata_o}, 32'h0);
    check(ev_ready == 1'b1, "R1", "ready after reset", 32'(ev_ready), 32'h1);
    for (int c = 0; c < 4; c++) run_cfg(c[1], c[0]);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule